// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block picks the power state a system drops into when its processor core signals that it is waiting for an interrupt or an event. The core supplies a one-cycle sleep request strobe. Three configuration levels travel with it: a deep-sleep bit, a three-bit mode code and a low-power-regulator run bit. When deep-sleep is clear, the request enters a light sleep in which only the core clock stops. When deep-sleep is set, the mode code selects one of three stop levels, standby or shutdown. A wake request brings the block back to run. Stop states resume with the system clock on the low-speed internal oscillator. Standby and shutdown leave through a system reset and set a sticky standby flag.

The state is presented one-hot. From that state the block drives the clock-gate enables, the oscillator and PLL enables, a regulator select and the SRAM retention controls. The analog regulators, the clock generators and the core are modelled only as these enables. After a stop exit, a programmable counter holds the clock-ready output low until the restarted clocks can be used.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the state is run (state_o = 8'h01). In this state cpu_clk_en_o, periph_clk_en_o, hs_osc_en_o, pll_en_o and clk_ready_o are all 1, stby_flag_o and wake_rst_o are 0, and reg_sel_o is the main regulator.
- R2: In run with deep_sleep_i = 0 and lp_reg_run_i = 0, a sleep request enters sleep (state_o bit 1) whatever mode_sel_i holds. In sleep only cpu_clk_en_o is low and periph_clk_en_o stays 1.
- R3: In run with deep_sleep_i = 0 and lp_reg_run_i = 1, a sleep request enters low-power sleep (state_o bit 2). The regulator select is the low-power regulator in low-power sleep and in run while lp_reg_run_i = 1.
- R4: With deep_sleep_i = 1, mode_sel_i selects the state: 000 gives stop0 (bit 3), 001 gives stop1 (bit 4), 010 gives stop2 (bit 5), 011 gives standby (bit 6), and any code 1xx gives shutdown (bit 7).
- R5: reg_sel_o is 2'b00 (main) in stop0, 2'b01 (low-power) in stop1 and stop2, and 2'b10 (off) in standby and shutdown.
- R6: In every stop state hs_osc_en_o, pll_en_o, cpu_clk_en_o and clk_ready_o are 0, and sram_ret_o is 1.
- R7: A wake request in sleep or low-power sleep returns the state to run on the next clock edge, with no reset pulse.
- R8: A wake request in a stop state returns the state to run on the next edge, with no reset pulse and with sysclk_lowspd_o = 1. hs_osc_en_o and pll_en_o stay 0 until an hs_restart_i strobe in run. clk_ready_o rises WAKE_CYC cycles after the return to run.
- R9: A wake request in standby or shutdown returns the state to run and raises wake_rst_o for exactly one cycle. It sets stby_flag_o, which stays 1 until a cycle with flag_clr_i = 1.
- R10: sram_ret_o is 0 in standby and shutdown. sram2_ret_o is 0 in shutdown. In standby, sram2_ret_o equals the value sram2_keep_i had on the entry cycle.
- R11: A sleep request made while wake_pend_i = 1 is refused, and the state stays run.
- R12: A sleep request is ignored outside run, and a wake request has no effect in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| deep_sleep_i | input | 1 | Deep-sleep select from the core |
| mode_sel_i | input | 3 | Deep-sleep mode code |
| lp_reg_run_i | input | 1 | Low-power regulator run mode |
| sram2_keep_i | input | 1 | Keep the second SRAM bank powered in standby |
| sleep_req_i | input | 1 | Wait-for-interrupt/event strobe |
| wake_req_i | input | 1 | Wakeup request |
| wake_pend_i | input | 1 | A wakeup flag is already pending |
| flag_clr_i | input | 1 | Write-1 clear of the standby flag |
| hs_restart_i | input | 1 | Software re-enables the high-speed oscillator and PLL |
| state_o | output | 8 | One-hot power state |
| cpu_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| hs_osc_en_o | output | 1 | High-speed oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| sysclk_lowspd_o | output | 1 | System clock runs from the low-speed internal oscillator |
| reg_sel_o | output | 2 | Regulator select: 00 main, 01 low-power, 10 off |
| sram_ret_o | output | 1 | SRAM and register retention |
| sram2_ret_o | output | 1 | Second SRAM bank power |
| clk_ready_o | output | 1 | Clocks usable |
| wake_rst_o | output | 1 | One-cycle system reset on wake from standby or shutdown |
| stby_flag_o | output | 1 | Sticky standby flag |

## Verification
The assertions check on every cycle that the state is one-hot, that a refused or ignored request leaves the state unchanged, that a light sleep exits without a reset pulse, that the reset pulse lasts a single cycle, and that the standby flag holds until it is cleared. They also check that stop states drop the fast clocks while keeping retention, and that clock-ready stays low through every stop. Only the bench scenarios can show the full mode-code decode with its regulator and SRAM-bank settings, the exact cycle on which clock-ready returns, the oscillator staying off until the software restart, and the flag-clear handshake.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int NSTATE = 8;

  typedef enum logic [NSTATE-1:0] {
    ST_RUN      = 8'h01,
    ST_SLEEP    = 8'h02,
    ST_LPSLEEP  = 8'h04,
    ST_STOP0    = 8'h08,
    ST_STOP1    = 8'h10,
    ST_STOP2    = 8'h20,
    ST_STANDBY  = 8'h40,
    ST_SHUTDOWN = 8'h80
  } pwr_state_e;

  typedef enum logic [1:0] {
    REG_MAIN = 2'b00,
    REG_LP   = 2'b01,
    REG_OFF  = 2'b10
  } reg_sel_e;

  function automatic logic is_stop(pwr_state_e s);
    return (s == ST_STOP0) || (s == ST_STOP1) || (s == ST_STOP2);
  endfunction

  function automatic logic is_reset_exit(pwr_state_e s);
    return (s == ST_STANDBY) || (s == ST_SHUTDOWN);
  endfunction

  function automatic logic is_light(pwr_state_e s);
    return (s == ST_SLEEP) || (s == ST_LPSLEEP);
  endfunction
endpackage

// File: rtl/lpm_select.sv
module lpm_select
  import lpm_pkg::*;
(
  input  logic       deep_sleep,
  input  logic [2:0] mode_sel,
  input  logic       lp_run,
  output pwr_state_e target
);
  always_comb begin
    if (!deep_sleep) begin
      target = lp_run ? ST_LPSLEEP : ST_SLEEP;
    end else if (mode_sel[2]) begin
      target = ST_SHUTDOWN;
    end else begin
      case (mode_sel[1:0])
        2'b00:   target = ST_STOP0;
        2'b01:   target = ST_STOP1;
        2'b10:   target = ST_STOP2;
        default: target = ST_STANDBY;
      endcase
    end
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e target,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       wake_pend,
  input  logic       sram2_keep,
  input  logic       flag_clr,
  input  logic       hs_restart,
  output pwr_state_e state,
  output logic       rst_pulse,
  output logic       stby_flag,
  output logic       sram2_hold,
  output logic       hs_off,
  output logic       stop_exit
);
  pwr_state_e state_q, state_d;
  logic       rst_pulse_q, rst_pulse_d;
  logic       flag_q, flag_d;
  logic       hold_q, hold_d;
  logic       hs_off_q, hs_off_d;
  logic       enter, in_run, exit_reset;

  always_comb begin
    in_run     = (state_q == ST_RUN);
    enter      = in_run && sleep_req && !wake_pend;
    exit_reset = wake_req && is_reset_exit(state_q);
    stop_exit  = wake_req && is_stop(state_q);

    state_d = state_q;
    if (enter)                 state_d = target;
    else if (!in_run && wake_req) state_d = ST_RUN;

    rst_pulse_d = exit_reset;

    flag_d = flag_q;
    if (exit_reset)    flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;

    hs_off_d = hs_off_q;
    if (enter && is_stop(target))    hs_off_d = 1'b1;
    else if (exit_reset)             hs_off_d = 1'b0;
    else if (in_run && hs_restart)   hs_off_d = 1'b0;

    hold_d = hold_q;
    if (enter && (target == ST_STANDBY)) hold_d = sram2_keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      rst_pulse_q <= 1'b0;
      flag_q      <= 1'b0;
      hs_off_q    <= 1'b0;
      hold_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      rst_pulse_q <= rst_pulse_d;
      flag_q      <= flag_d;
      hs_off_q    <= hs_off_d;
      hold_q      <= hold_d;
    end
  end

  assign state      = state_q;
  assign rst_pulse  = rst_pulse_q;
  assign stby_flag  = flag_q;
  assign sram2_hold = hold_q;
  assign hs_off     = hs_off_q;

  a_r4_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q) == 1);

  // R11: a pending wake flag refuses entry
  a_r11_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req && wake_pend) |=> (state_q == ST_RUN));

  a_r12_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN && !wake_req) |=> (state_q == $past(state_q)));

  a_r7_light_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (is_light(state_q) && wake_req) |=> (state_q == ST_RUN && !rst_pulse_q));

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse_q |=> !rst_pulse_q);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int WAKE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  generate
    if (WAKE_CYC == 0) begin : g_none
      assign done = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(WAKE_CYC + 1);
      localparam logic [CW-1:0] LOADV = CW'(WAKE_CYC);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = LOADV;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign done = (cnt_q == '0);

      a_r8_load_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);
    end
  endgenerate
endmodule

// File: rtl/lpm_outputs.sv
module lpm_outputs
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state,
  input  logic       lp_run,
  input  logic       sram2_hold,
  input  logic       hs_off,
  input  logic       cnt_done,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       hs_osc_en,
  output logic       pll_en,
  output logic       sysclk_lowspd,
  output reg_sel_e   reg_sel,
  output logic       sram_ret,
  output logic       sram2_ret,
  output logic       clk_ready
);
  logic deep, stop;

  always_comb begin
    stop          = is_stop(state);
    deep          = stop || is_reset_exit(state);
    cpu_clk_en    = (state == ST_RUN);
    periph_clk_en = (state == ST_RUN) || is_light(state);
    hs_osc_en     = !deep && !hs_off;
    pll_en        = !deep && !hs_off;
    sysclk_lowspd = hs_off;
    clk_ready     = !deep && cnt_done;
    sram_ret      = !is_reset_exit(state);
    case (state)
      ST_SHUTDOWN: sram2_ret = 1'b0;
      ST_STANDBY:  sram2_ret = sram2_hold;
      default:     sram2_ret = 1'b1;
    endcase
    case (state)
      ST_RUN:      reg_sel = lp_run ? REG_LP : REG_MAIN;
      ST_SLEEP:    reg_sel = REG_MAIN;
      ST_LPSLEEP:  reg_sel = REG_LP;
      ST_STOP0:    reg_sel = REG_MAIN;
      ST_STOP1:    reg_sel = REG_LP;
      ST_STOP2:    reg_sel = REG_LP;
      default:     reg_sel = REG_OFF;
    endcase
  end

  a_r6_stop_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    is_stop(state) |-> (!hs_osc_en && !pll_en && !cpu_clk_en && sram_ret));

  a_r8_stop_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    is_stop(state) |-> !clk_ready);

  a_r10_shutdown_bank_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHUTDOWN) |-> (!sram2_ret && !sram_ret));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int WAKE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       deep_sleep_i,
  input  logic [2:0] mode_sel_i,
  input  logic       lp_reg_run_i,
  input  logic       sram2_keep_i,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  input  logic       wake_pend_i,
  input  logic       flag_clr_i,
  input  logic       hs_restart_i,
  output logic [7:0] state_o,
  output logic       cpu_clk_en_o,
  output logic       periph_clk_en_o,
  output logic       hs_osc_en_o,
  output logic       pll_en_o,
  output logic       sysclk_lowspd_o,
  output logic [1:0] reg_sel_o,
  output logic       sram_ret_o,
  output logic       sram2_ret_o,
  output logic       clk_ready_o,
  output logic       wake_rst_o,
  output logic       stby_flag_o
);
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  pwr_state_e target, state;
  reg_sel_e   reg_sel;
  logic       sram2_hold, hs_off, stop_exit, cnt_done;

  lpm_select u_select (
    .deep_sleep (deep_sleep_i),
    .mode_sel   (mode_sel_i),
    .lp_run     (lp_reg_run_i),
    .target     (target)
  );

  lpm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .target     (target),
    .sleep_req  (sleep_req_i),
    .wake_req   (wake_req_i),
    .wake_pend  (wake_pend_i),
    .sram2_keep (sram2_keep_i),
    .flag_clr   (flag_clr_i),
    .hs_restart (hs_restart_i),
    .state      (state),
    .rst_pulse  (wake_rst_o),
    .stby_flag  (stby_flag_o),
    .sram2_hold (sram2_hold),
    .hs_off     (hs_off),
    .stop_exit  (stop_exit)
  );

  lpm_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load  (stop_exit),
    .done  (cnt_done)
  );

  lpm_outputs u_out (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .state         (state),
    .lp_run        (lp_reg_run_i),
    .sram2_hold    (sram2_hold),
    .hs_off        (hs_off),
    .cnt_done      (cnt_done),
    .cpu_clk_en    (cpu_clk_en_o),
    .periph_clk_en (periph_clk_en_o),
    .hs_osc_en     (hs_osc_en_o),
    .pll_en        (pll_en_o),
    .sysclk_lowspd (sysclk_lowspd_o),
    .reg_sel       (reg_sel),
    .sram_ret      (sram_ret_o),
    .sram2_ret     (sram2_ret_o),
    .clk_ready     (clk_ready_o)
  );

  assign state_o   = state;
  assign reg_sel_o = reg_sel;
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic deep_sleep_i, lp_reg_run_i, sram2_keep_i, sleep_req_i;
  logic wake_req_i, wake_pend_i, flag_clr_i, hs_restart_i;
  logic [2:0] mode_sel_i;
  logic [7:0] state_o;
  logic [1:0] reg_sel_o;
  logic cpu_clk_en_o, periph_clk_en_o, hs_osc_en_o, pll_en_o, sysclk_lowspd_o;
  logic sram_ret_o, sram2_ret_o, clk_ready_o, wake_rst_o, stby_flag_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpm_ctrl #(.WAKE_CYC(W)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic req_sleep(input logic ds, input logic [2:0] mode, input logic lpr);
    @(negedge clk);
    deep_sleep_i = ds; mode_sel_i = mode; lp_reg_run_i = lpr; sleep_req_i = 1'b1;
    @(negedge clk);
    sleep_req_i = 1'b0;
  endtask

  task automatic do_wake();
    @(negedge clk); wake_req_i = 1'b1;
    @(negedge clk); wake_req_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", state_o, 8'h01);
    chk("R1 enables", {cpu_clk_en_o, periph_clk_en_o, hs_osc_en_o, pll_en_o, clk_ready_o}, 5'b11111);
    chk("R1 flag/pulse", {stby_flag_o, wake_rst_o}, 2'b00);
    chk("R1 reg", reg_sel_o, 2'b00);
  endtask

  task automatic t_sleep();
    req_sleep(1'b0, 3'b100, 1'b0);
    chk("R2 sleep state", state_o, 8'h02);
    chk("R2 clocks", {cpu_clk_en_o, periph_clk_en_o, hs_osc_en_o}, 3'b011);
    // R12: sleep request in sleep ignored
    req_sleep(1'b1, 3'b010, 1'b0);
    chk("R12 req ignored", state_o, 8'h02);
    do_wake();
    chk("R7 back to run", state_o, 8'h01);
    chk("R7 no reset", wake_rst_o, 1'b0);
  endtask

  task automatic t_lpsleep();
    @(negedge clk); lp_reg_run_i = 1'b1;
    @(negedge clk);
    chk("R3 lp run reg", reg_sel_o, 2'b01);
    req_sleep(1'b0, 3'b000, 1'b1);
    chk("R3 lpsleep", state_o, 8'h04);
    chk("R3 lpsleep reg", reg_sel_o, 2'b01);
    do_wake();
    chk("R7 lp wake", state_o, 8'h01);
    @(negedge clk); lp_reg_run_i = 1'b0;
  endtask

  task automatic t_stop(input logic [2:0] mode, input logic [7:0] st, input logic [1:0] rg);
    req_sleep(1'b1, mode, 1'b0);
    chk("R4 stop decode", state_o, st);
    chk("R5 stop reg", reg_sel_o, rg);
    chk("R6 stop outputs", {hs_osc_en_o, pll_en_o, cpu_clk_en_o, clk_ready_o, sram_ret_o}, 5'b00001);
    do_wake();
    chk("R8 resume run", state_o, 8'h01);
    chk("R8 no reset", wake_rst_o, 1'b0);
    chk("R8 low speed", {sysclk_lowspd_o, hs_osc_en_o, pll_en_o}, 3'b100);
    chk("R8 not ready yet", clk_ready_o, 1'b0);
    repeat (W - 1) @(negedge clk);
    chk("R8 ready late", clk_ready_o, 1'b0);
    @(negedge clk);
    chk("R8 ready on time", clk_ready_o, 1'b1);
    chk("R8 hs still off", hs_osc_en_o, 1'b0);
    @(negedge clk); hs_restart_i = 1'b1;
    @(negedge clk); hs_restart_i = 1'b0;
    chk("R8 hs restarted", {hs_osc_en_o, pll_en_o, sysclk_lowspd_o}, 3'b110);
  endtask

  task automatic t_standby();
    @(negedge clk); sram2_keep_i = 1'b1;
    req_sleep(1'b1, 3'b011, 1'b0);
    @(negedge clk); sram2_keep_i = 1'b0;
    chk("R4 standby", state_o, 8'h40);
    chk("R5 standby reg", reg_sel_o, 2'b10);
    chk("R10 standby bank", {sram_ret_o, sram2_ret_o}, 2'b01);
    do_wake();
    chk("R9 run", state_o, 8'h01);
    chk("R9 pulse", wake_rst_o, 1'b1);
    chk("R9 flag", stby_flag_o, 1'b1);
    @(negedge clk);
    chk("R9 pulse single", wake_rst_o, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", stby_flag_o, 1'b1);
    @(negedge clk); flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
    chk("R9 flag cleared", stby_flag_o, 1'b0);
  endtask

  task automatic t_standby_nokeep();
    req_sleep(1'b1, 3'b011, 1'b0);
    chk("R10 standby no keep", sram2_ret_o, 1'b0);
    do_wake();
    @(negedge clk); flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
  endtask

  task automatic t_shutdown(input logic [2:0] mode);
    @(negedge clk); sram2_keep_i = 1'b1;
    req_sleep(1'b1, mode, 1'b0);
    chk("R4 shutdown", state_o, 8'h80);
    chk("R5 shutdown reg", reg_sel_o, 2'b10);
    chk("R10 shutdown bank", {sram_ret_o, sram2_ret_o}, 2'b00);
    do_wake();
    chk("R9 shutdown pulse", {wake_rst_o, stby_flag_o, state_o}, {2'b11, 8'h01});
    @(negedge clk); sram2_keep_i = 1'b0; flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
  endtask

  task automatic t_pending();
    @(negedge clk); wake_pend_i = 1'b1;
    req_sleep(1'b1, 3'b001, 1'b0);
    chk("R11 refused", state_o, 8'h01);
    @(negedge clk); wake_pend_i = 1'b0;
  endtask

  task automatic t_wake_in_run();
    do_wake();
    chk("R12 wake in run", {state_o, wake_rst_o, stby_flag_o}, {8'h01, 2'b00});
  endtask

  initial begin
    rst_n = 1'b0;
    deep_sleep_i = 0; mode_sel_i = 0; lp_reg_run_i = 0; sram2_keep_i = 0;
    sleep_req_i = 0; wake_req_i = 0; wake_pend_i = 0; flag_clr_i = 0; hs_restart_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_sleep();
    t_lpsleep();
    t_stop(3'b000, 8'h08, 2'b00);
    t_stop(3'b001, 8'h10, 2'b01);
    t_stop(3'b010, 8'h20, 2'b01);
    t_standby();
    t_standby_nokeep();
    t_shutdown(3'b100);
    t_shutdown(3'b111);
    t_pending();
    t_wake_in_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule